// File: doc/BRIEF.md
# Command/Status Register Pair with Fixed-Length Operation Timer

This block gives software a two-register window onto a data-processing engine. One register accepts commands and is never read back; the other reports two flags, a "ready" flag and a "finished" flag. Software raises or drops the ready flag with command bits. It then issues a start command, which launches an operation of fixed length only while the ready flag is up. When the operation's fixed delay expires, the finished flag rises, and it stays up until software clears it with another command. The engine's datapath is not part of the block. It is stood in for by the completion delay.

Access is over a simple synchronous bus. An address, a write strobe with write data and a read strobe are sampled on the rising clock edge. Read data is registered and appears in the cycle after the read strobe. Outside a read it returns zero.

A two-state timer FSM does the counting. `TMR_IDLE` waits for an accepted start and moves to `TMR_COUNT` while loading the counter (transition *launch*). `TMR_COUNT` decrements the counter each cycle. When the counter reaches zero it returns to `TMR_IDLE` and pulses completion (transition *finish*). A start seen in `TMR_COUNT` causes no transition.

Top module: `ctl_stat_regs`

## Requirements
- R1: A synchronous active-high reset clears the ready flag, the finished flag and the timer, and forces read data to 0. A reset during a countdown cancels it, so the finished flag stays 0 afterwards.
- R2: The status register sits at offset 0x0, with the ready flag in bit 1 and the finished flag in bit 0. A read returns the flags as they stood before the edge that sampled the read strobe, on the cycle after that strobe.
- R3: The command register sits at offset 0x4. A write there with bit 3 (set-ready) at 1 and bit 2 (clear-ready) at 0 sets the ready flag. A write with bit 2 at 1 and bit 3 at 0 clears it.
- R4: A command write with bits 3 and 2 both at 1 leaves the ready flag unchanged.
- R5: Command bit 0 (start) launches an operation only if the ready flag, after the same write's set/clear update, is 1. So 0b1001 sets the flag and launches, and 0b0101 clears it without launching.
- R6: The finished flag becomes 1 on the fifth rising edge after the edge that accepted a start. A status read issued right after the start write shows ready=1 and finished=0.
- R7: A command write with bit 1 (clear-finished) at 1 clears the finished flag.
- R8: A start received while a countdown is running is ignored. It does not restart or extend the countdown.
- R9: If clear-finished is written on the same edge where the countdown completes, the finished flag ends at 1.
- R10: Reads of offset 0x4 and of unmapped offsets return 0. Writes to any offset other than 0x4, including the status offset, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (4) | Byte offset of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (4) | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (4) | Registered read data, valid the cycle after bus_re |

## Verification
The ready flag is driven with set alone, clear alone and both together, starting from each flag value. This separates a hold on conflict from either bit winning. Starts are issued with the flag down, with it raised by the same write, and with it dropped by the same write. Together these show whether the gate uses the updated flag or the old one. Back-to-back status reads after a start find the exact completion edge. A second start mid-count and a clear-finished landing on the completion edge tell "ignored" apart from "restarted", and "completion wins" apart from "clear wins". Accesses to the command offset, the status offset and unmapped offsets show that nothing leaks through the decoder.

// File: rtl/csr_pkg.sv
package csr_pkg;

    // Command register bit positions (software-visible encoding)
    localparam int CMD_START_BIT    = 0;
    localparam int CMD_CLRDONE_BIT  = 1;
    localparam int CMD_CLRREADY_BIT = 2;
    localparam int CMD_SETREADY_BIT = 3;

    // Status register bit positions
    localparam int STS_DONE_BIT  = 0;
    localparam int STS_READY_BIT = 1;

    // Highest bit position used by either register
    localparam int MAP_TOP_BIT = 3;

    typedef struct packed {
        logic set_ready;
        logic clr_ready;
        logic clr_done;
        logic start;
    } cmd_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_COMMAND
    } rd_sel_e;

    typedef enum logic {
        TMR_IDLE,
        TMR_COUNT
    } tmr_state_e;

endpackage

// File: rtl/csr_decode.sv
module csr_decode
    import csr_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 4,
    parameter int STATUS_OFS = 0,
    parameter int CMD_OFS    = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output cmd_t              cmd,
    output rd_sel_e           rd_sel
);

    localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(STATUS_OFS);
    localparam logic [ADDR_W-1:0] CMD_A    = ADDR_W'(CMD_OFS);

    logic hit_status;
    logic hit_cmd;
    logic wr_cmd;

    assign hit_status = (addr == STATUS_A);
    assign hit_cmd    = (addr == CMD_A);
    assign wr_cmd     = we && hit_cmd;

    always_comb begin
        cmd.set_ready = wr_cmd && wdata[CMD_SETREADY_BIT];
        cmd.clr_ready = wr_cmd && wdata[CMD_CLRREADY_BIT];
        cmd.clr_done  = wr_cmd && wdata[CMD_CLRDONE_BIT];
        cmd.start     = wr_cmd && wdata[CMD_START_BIT];
    end

    always_comb begin
        if (hit_status) begin
            rd_sel = SEL_STATUS;
        end else if (hit_cmd) begin
            rd_sel = SEL_COMMAND;
        end else begin
            rd_sel = SEL_NONE;
        end
    end

    // R10: commands only ever come from the command offset
    always_comb begin
        if (!hit_cmd) begin
            assert (cmd == '0)
                else $error("p_cmd_only_at_offset_r10 violated");
        end
    end

endmodule

// File: rtl/csr_op_timer.sv
module csr_op_timer
    import csr_pkg::*;
#(
    parameter int OP_CYCLES = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic start_req,
    input  logic ready_next,
    output logic done_evt,
    output logic busy
);

    localparam int CNT_W = (OP_CYCLES > 1) ? $clog2(OP_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(OP_CYCLES - 1);

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             accept;

    assign accept = start_req && ready_next && (state_q == TMR_IDLE);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state: launch (IDLE->COUNT), finish (COUNT->IDLE)
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TMR_IDLE: begin
                if (accept) begin
                    state_d = TMR_COUNT;
                    cnt_d   = CNT_LOAD;
                end
            end
            TMR_COUNT: begin
                if (cnt_q == '0) begin
                    state_d = TMR_IDLE;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            default: begin
                state_d = TMR_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        done_evt = 1'b0;
        busy     = 1'b0;
        unique case (state_q)
            TMR_IDLE:  ;
            TMR_COUNT: begin
                busy     = 1'b1;
                done_evt = (cnt_q == '0);
            end
            default: ;
        endcase
    end

    // Checker counter: edges since the accepting edge
    int elapsed_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            elapsed_q <= 0;
        end else if (accept) begin
            elapsed_q <= 1;
        end else if (state_q == TMR_COUNT) begin
            elapsed_q <= elapsed_q + 1;
        end
    end

    // R8: a running countdown only moves down by one, whatever arrives
    p_count_down_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == TMR_COUNT && cnt_q != '0) |=>
            (state_q == TMR_COUNT && cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R5: start with the updated ready flag low is refused
    p_start_gate_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == TMR_IDLE && start_req && !ready_next) |=> (state_q == TMR_IDLE));

    // R5: start with the updated ready flag high launches
    p_start_launch_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == TMR_IDLE && start_req && ready_next) |=>
            (state_q == TMR_COUNT && cnt_q == CNT_LOAD));

    // R6: completion lands exactly OP_CYCLES edges after acceptance
    p_done_timing_r6: assert property (@(posedge clk) disable iff (rst)
        done_evt |-> (elapsed_q == OP_CYCLES));

endmodule

// File: rtl/csr_flags.sv
module csr_flags
    import csr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cmd_t cmd,
    input  logic done_evt,
    output logic ready_q,
    output logic ready_next,
    output logic done_q
);

    // Set/clear resolution; a conflict holds the flag
    always_comb begin
        unique case ({cmd.set_ready, cmd.clr_ready})
            2'b10:   ready_next = 1'b1;
            2'b01:   ready_next = 1'b0;
            default: ready_next = ready_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q <= 1'b0;
        end else begin
            ready_q <= ready_next;
        end
    end

    // Completion has priority over a same-cycle clear
    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
        end else if (done_evt) begin
            done_q <= 1'b1;
        end else if (cmd.clr_done) begin
            done_q <= 1'b0;
        end
    end

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!ready_q && !done_q));

    p_ready_set_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd.set_ready && !cmd.clr_ready) |=> ready_q);

    p_ready_clr_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd.clr_ready && !cmd.set_ready) |=> !ready_q);

    p_ready_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd.set_ready && cmd.clr_ready) |=> $stable(ready_q));

    p_done_clr_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd.clr_done && !done_evt) |=> !done_q);

    p_done_wins_r9: assert property (@(posedge clk) disable iff (rst)
        done_evt |=> done_q);

endmodule

// File: rtl/ctl_stat_regs.sv
module ctl_stat_regs
    import csr_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 4,
    parameter int STATUS_OFS = 0,
    parameter int CMD_OFS    = 4,
    parameter int OP_CYCLES  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata
);

    initial begin
        assert (DATA_W > MAP_TOP_BIT)
            else $error("DATA_W too narrow for the register map");
    end

    cmd_t        cmd;
    rd_sel_e     rd_sel;
    logic        ready_q;
    logic        ready_next;
    logic        done_q;
    logic        done_evt;
    logic        busy;
    logic [DATA_W-1:0] status_word;

    csr_decode #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .STATUS_OFS(STATUS_OFS),
        .CMD_OFS   (CMD_OFS)
    ) u_decode (
        .addr  (bus_addr),
        .we    (bus_we),
        .wdata (bus_wdata),
        .cmd   (cmd),
        .rd_sel(rd_sel)
    );

    csr_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .done_evt  (done_evt),
        .ready_q   (ready_q),
        .ready_next(ready_next),
        .done_q    (done_q)
    );

    csr_op_timer #(
        .OP_CYCLES(OP_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .start_req (cmd.start),
        .ready_next(ready_next),
        .done_evt  (done_evt),
        .busy      (busy)
    );

    always_comb begin
        status_word                = '0;
        status_word[STS_READY_BIT] = ready_q;
        status_word[STS_DONE_BIT]  = done_q;
    end

    // Registered read-back; zero outside a status read
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_re) begin
            unique case (rd_sel)
                SEL_STATUS:  bus_rdata <= status_word;
                SEL_COMMAND: bus_rdata <= '0;
                default:     bus_rdata <= '0;
            endcase
        end else begin
            bus_rdata <= '0;
        end
    end

    p_rd_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_re && rd_sel != SEL_STATUS) |=> (bus_rdata == '0));

    p_rd_status_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_re && rd_sel == SEL_STATUS) |=>
            (bus_rdata[STS_READY_BIT] == $past(ready_q) &&
             bus_rdata[STS_DONE_BIT]  == $past(done_q)));

    p_done_needs_busy_r6: assert property (@(posedge clk) disable iff (rst)
        done_evt |-> busy);

endmodule

// File: tb/sim_ctl_stat_regs.sv
module sim_ctl_stat_regs;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] bus_addr;
    logic       bus_we;
    logic [3:0] bus_wdata;
    logic       bus_re;
    logic [3:0] bus_rdata;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    ctl_stat_regs u0 (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_re   (bus_re),
        .bus_rdata(bus_rdata)
    );

    localparam logic [3:0] A_STS = 4'h0;
    localparam logic [3:0] A_CMD = 4'h4;

    task automatic chk(input string req, input string what,
                       input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [3:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
        bus_wdata = 4'h0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [3:0] d);
        bus_addr = a;
        bus_re   = 1'b1;
        @(negedge clk);
        bus_re   = 1'b0;
        d        = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input string what,
                          input logic [3:0] a, input logic [3:0] exp);
        logic [3:0] d;
        rd(a, d);
        chk(req, what, d, exp);
    endtask

    task automatic t_reset();
        chk("R1", "rdata during reset", bus_rdata, 4'b0000);
        rd_chk("R2", "status after reset", A_STS, 4'b0000);
    endtask

    task automatic t_set_clear();
        wr(A_CMD, 4'b1000);
        rd_chk("R3", "set-ready", A_STS, 4'b0010);
        wr(A_CMD, 4'b0100);
        rd_chk("R3", "clear-ready", A_STS, 4'b0000);
    endtask

    task automatic t_conflict();
        wr(A_CMD, 4'b1100);
        rd_chk("R4", "both from 0", A_STS, 4'b0000);
        wr(A_CMD, 4'b1000);
        wr(A_CMD, 4'b1100);
        rd_chk("R4", "both from 1", A_STS, 4'b0010);
        wr(A_CMD, 4'b0100);
    endtask

    task automatic t_start_gate();
        wr(A_CMD, 4'b0001);
        idle(8);
        rd_chk("R5", "start with ready low", A_STS, 4'b0000);
        wr(A_CMD, 4'b1001);
        rd_chk("R5", "0b1001 immediate read", A_STS, 4'b0010);
        idle(8);
        rd_chk("R5", "0b1001 completes", A_STS, 4'b0011);
        wr(A_CMD, 4'b0010);
        wr(A_CMD, 4'b0101);
        idle(8);
        rd_chk("R5", "0b0101 refused", A_STS, 4'b0000);
    endtask

    task automatic t_timing();
        wr(A_CMD, 4'b1000);
        wr(A_CMD, 4'b0001);
        for (int i = 0; i < 5; i++)
            rd_chk("R6", $sformatf("before completion read %0d", i), A_STS, 4'b0010);
        rd_chk("R6", "at completion", A_STS, 4'b0011);
        wr(A_CMD, 4'b0010);
        rd_chk("R7", "clear-finished", A_STS, 4'b0010);
    endtask

    task automatic t_restart();
        wr(A_CMD, 4'b0001);
        idle(1);
        wr(A_CMD, 4'b0001);
        for (int i = 0; i < 3; i++)
            rd_chk("R8", $sformatf("mid-count read %0d", i), A_STS, 4'b0010);
        rd_chk("R8", "original deadline kept", A_STS, 4'b0011);
        wr(A_CMD, 4'b0010);
    endtask

    task automatic t_clr_race();
        wr(A_CMD, 4'b0001);
        idle(4);
        wr(A_CMD, 4'b0010);
        rd_chk("R9", "completion beats clear", A_STS, 4'b0011);
        wr(A_CMD, 4'b0010);
        rd_chk("R7", "later clear", A_STS, 4'b0010);
    endtask

    task automatic t_map();
        rd_chk("R10", "command offset reads 0", A_CMD, 4'b0000);
        rd_chk("R10", "unmapped 0x8 reads 0", 4'h8, 4'b0000);
        wr(4'h8, 4'b0100);
        rd_chk("R10", "unmapped write ignored", A_STS, 4'b0010);
        wr(A_STS, 4'b0100);
        rd_chk("R10", "status write ignored", A_STS, 4'b0010);
        wr(4'hC, 4'b0001);
        idle(8);
        rd_chk("R10", "unmapped start ignored", A_STS, 4'b0010);
    endtask

    task automatic t_reset_mid();
        wr(A_CMD, 4'b0001);
        idle(2);
        rst = 1'b1;
        idle(1);
        rst = 1'b0;
        rd_chk("R1", "flags after mid-count reset", A_STS, 4'b0000);
        idle(8);
        rd_chk("R1", "cancelled countdown", A_STS, 4'b0000);
    endtask

    initial begin
        rst       = 1'b1;
        bus_addr  = 4'h0;
        bus_we    = 1'b0;
        bus_wdata = 4'h0;
        bus_re    = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        rd_chk("R2", "status idle", A_STS, 4'b0000);
        t_set_clear();
        t_conflict();
        t_start_gate();
        t_timing();
        t_restart();
        t_clr_race();
        t_map();
        t_reset_mid();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule